// File: doc/BRIEF.md
# SPI Flash Status Register Engine

This block models the status-register side of a serial flash device. A host reaches it over an SPI mode 0 slave port made of chip select, serial clock, data in and data out. The block samples all of these inputs with its own system clock. It recognises three instructions. Write enable arms a latch. Read status streams the status byte back to the host. Write status loads new protection settings into the register.

A write status instruction only takes effect when three conditions all hold. The write enable latch must have been set earlier. Chip select must rise right after the sixteenth bit. Hardware protection must not be active. Hardware protection applies when the write disable bit is set and the active-low protect pin is held low. An accepted write starts a self-timed cycle whose length, in clock cycles, is set by a parameter. During that cycle the write-in-progress flag reads 1, and a host can poll it through read status. The write enable latch clears when the cycle ends.

Top module: `sfsr_engine`

## Requirements
- R1: A write status instruction takes effect only if the write enable latch (status bit 1) is set. The write enable instruction sets the latch, but only when chip select rises after exactly 8 bits.
- R2: Instruction codes are 06h for write enable, 05h for read status and 01h for write status. Each code is 8 bits, sent MSB first and sampled on rising serial clock edges. Any other code has no effect.
- R3: A write status instruction carries one data byte, MSB first, after its code. It takes effect only if chip select rises after exactly 16 bits. With any other bit count the register is left unchanged.
- R4: The status byte layout is: bit 0 write-in-progress, bit 1 write enable latch, bit 2 block protect 0, bit 3 block protect 1, bit 7 write disable. A write changes only bits 7, 3 and 2. Bits 6 to 4 always read 0.
- R5: An accepted write updates bits 7, 3 and 2 at once. Write-in-progress then reads 1 for WRITE_CYCLES clocks and returns to 0.
- R6: The write enable latch clears no later than the clock on which write-in-progress returns to 0.
- R7: After code 05h, the live status byte is shifted out MSB first on falling serial clock edges. It repeats every 8 bits until chip select rises. The output enable is low whenever chip select is high.
- R8: While write-in-progress is 1, every instruction except read status is ignored.
- R9: When the write disable bit is 1 and wp_n is low, write status is ignored and the write enable latch stays set.
- R10: After reset the status byte reads 00h and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial port |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low write protect pin |
| sdo | output | 1 | Serial data to the host |
| sdo_en | output | 1 | Output enable for sdo; sdo is undriven when this is low |

## Verification
The checks assume that the serial inputs move slowly compared with clk. Each serial clock level must last at least three system clocks so that the two-stage sampler sees every edge. The serial clock must be low whenever chip select changes, and wp_n must not change in the middle of a transaction. The bench meets these conditions by driving every input on the falling edge of clk. It holds each serial clock phase for four clocks and sets wp_n only between transactions. Under these conditions the one-cycle pulses from the decoder line up with the timer and the register state that the assertions compare them against.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;

  localparam int B_WIP  = 0;
  localparam int B_WEL  = 1;
  localparam int B_BP0  = 2;
  localparam int B_BP1  = 3;
  localparam int B_SRWD = 7;

  typedef struct packed {
    logic       wdis;
    logic [1:0] bp;
  } sfsr_cfg_t;
endpackage

// File: rtl/sfsr_spi_front.sv
module sfsr_spi_front (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic cs_s,
  output logic sel_start,
  output logic sel_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic din
);
  logic cs1, cs2, sck1, sck2, mosi1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs1   <= 1'b1;
      cs2   <= 1'b1;
      sck1  <= 1'b0;
      sck2  <= 1'b0;
      mosi1 <= 1'b0;
    end else begin
      cs1   <= cs_n;
      cs2   <= cs1;
      sck1  <= sck;
      sck2  <= sck1;
      mosi1 <= mosi;
    end
  end

  assign cs_s      = cs1;
  assign sel_start = !cs1 && cs2;
  assign sel_end   = cs1 && !cs2;
  assign sck_rise  = !cs1 && sck1 && !sck2;
  assign sck_fall  = !cs1 && !sck1 && sck2;
  assign din       = mosi1;
endmodule

// File: rtl/sfsr_cmd_decode.sv
module sfsr_cmd_decode
  import sfsr_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_start,
  input  logic      sel_end,
  input  logic      sck_rise,
  input  logic      din,
  input  logic      busy,
  input  logic      wel,
  input  logic      hw_lock,
  output logic      wren_pulse,
  output logic      wrsr_pulse,
  output sfsr_cfg_t wr_cfg,
  output logic      rd_active
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(8);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(16);

  logic [7:0]       shreg;
  logic [7:0]       opcode;
  logic [CNT_W-1:0] bitcnt;
  logic [7:0]       next_byte;

  assign next_byte = {shreg[6:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      opcode    <= '0;
      bitcnt    <= '0;
      rd_active <= 1'b0;
    end else if (sel_start) begin
      bitcnt    <= '0;
      opcode    <= '0;
      rd_active <= 1'b0;
    end else if (sel_end) begin
      rd_active <= 1'b0;
    end else if (sck_rise) begin
      shreg <= next_byte;
      if (bitcnt != CNT_MAX) bitcnt <= bitcnt + 1'b1;
      if (bitcnt == CNT_OP - 1'b1) begin
        opcode <= next_byte;
        if (next_byte == OP_RDSR) rd_active <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_pulse <= 1'b0;
      wrsr_pulse <= 1'b0;
      wr_cfg     <= '0;
    end else begin
      wren_pulse <= sel_end && bitcnt == CNT_OP && opcode == OP_WREN && !busy;
      wrsr_pulse <= sel_end && bitcnt == CNT_DATA && opcode == OP_WRSR
                    && !busy && wel && !hw_lock;
      wr_cfg     <= '{wdis: shreg[B_SRWD], bp: shreg[B_BP1:B_BP0]};
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(wren_pulse && wrsr_pulse));
endmodule

// File: rtl/sfsr_wr_timer.sv
module sfsr_wr_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CW'(CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = cnt != '0;
  assign done = cnt == CW'(1);

  a_r5_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/sfsr_status_reg.sv
module sfsr_status_reg
  import sfsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wren,
  input  logic       wrsr,
  input  sfsr_cfg_t  wr_cfg,
  input  logic       busy,
  input  logic       done,
  input  logic       wp_n,
  output logic [7:0] status
);
  sfsr_cfg_t cfg_q;
  logic      wel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      wel_q <= 1'b0;
    end else begin
      if (wrsr)      cfg_q <= wr_cfg;
      if (done)      wel_q <= 1'b0;
      else if (wren) wel_q <= 1'b1;
    end
  end

  always_comb begin
    status         = '0;
    status[B_WIP]  = busy;
    status[B_WEL]  = wel_q;
    status[B_BP0]  = cfg_q.bp[0];
    status[B_BP1]  = cfg_q.bp[1];
    status[B_SRWD] = cfg_q.wdis;
  end

  a_r1_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr |-> wel_q);
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wrsr |=> $stable(cfg_q));
  a_r8_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(wrsr || wren));
  a_r9_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr |-> !(cfg_q.wdis && !wp_n));
endmodule

// File: rtl/sfsr_sdo_shift.sv
module sfsr_sdo_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_s,
  input  logic       rd_active,
  input  logic       sck_fall,
  input  logic [7:0] status,
  output logic       sdo,
  output logic       sdo_en
);
  logic [2:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else begin
      sdo_en <= !cs_s;
      if (!rd_active) begin
        idx <= '0;
        sdo <= 1'b0;
      end else if (sck_fall) begin
        sdo <= status[3'd7 - idx];
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfsr_engine.sv
module sfsr_engine
  import sfsr_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic sdo,
  output logic sdo_en
);
  logic      cs_s, sel_start, sel_end, sck_rise, sck_fall, din;
  logic      wren_pulse, wrsr_pulse, rd_active, busy, done, hw_lock;
  sfsr_cfg_t wr_cfg;
  logic [7:0] status;

  sfsr_spi_front u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .cs_s(cs_s), .sel_start(sel_start), .sel_end(sel_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .din(din)
  );

  assign hw_lock = status[B_SRWD] && !wp_n;

  sfsr_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .sel_end(sel_end),
    .sck_rise(sck_rise), .din(din), .busy(busy), .wel(status[B_WEL]),
    .hw_lock(hw_lock), .wren_pulse(wren_pulse), .wrsr_pulse(wrsr_pulse),
    .wr_cfg(wr_cfg), .rd_active(rd_active)
  );

  sfsr_wr_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wrsr_pulse), .busy(busy), .done(done)
  );

  sfsr_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .wren(wren_pulse), .wrsr(wrsr_pulse),
    .wr_cfg(wr_cfg), .busy(busy), .done(done), .wp_n(wp_n), .status(status)
  );

  sfsr_sdo_shift u_sdo (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rd_active(rd_active),
    .sck_fall(sck_fall), .status(status), .sdo(sdo), .sdo_en(sdo_en)
  );

  a_r5_commit_starts_wip: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_pulse |=> status[B_WIP]);
  a_r6_latch_gone_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[B_WIP]) |-> !status[B_WEL]);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_en);
  a_r4_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> status[6:4] == 3'b000);
endmodule

// File: tb/sfsr_engine_test.sv
module sfsr_engine_test;
  localparam int WCYC = 300;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic sdo, sdo_en;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sfsr_engine #(.WRITE_CYCLES(WCYC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .sdo(sdo), .sdo_en(sdo_en)
  );

  // {wp_n, data byte, expected final status}
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'hFF, 8'h8C},
    {1'b1, 8'h00, 8'h00},
    {1'b0, 8'h84, 8'h84},
    {1'b0, 8'h00, 8'h86},
    {1'b1, 8'h08, 8'h08},
    {1'b1, 8'h7B, 8'h08},
    {1'b0, 8'hF3, 8'h80},
    {1'b0, 8'h8C, 8'h82}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic spi_xfer(input logic [23:0] word, input int nbits, output logic [23:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = word[23-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[22:0], sdo};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [23:0] rx;
    spi_xfer({8'h05, 16'h0}, 16, rx);
    s = rx[7:0];
  endtask

  task automatic wren(input int nbits);
    logic [23:0] rx;
    spi_xfer({8'h06, 16'h0}, nbits, rx);
  endtask

  task automatic wrsr(input logic [7:0] d, input int nbits);
    logic [23:0] rx;
    spi_xfer({8'h01, d, 8'h0}, nbits, rx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s, prev, imm;
    logic [23:0] rx;
    logic saw_busy;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10: reset state
    chk("R10 sdo_en", {7'b0, sdo_en}, 8'h00);
    read_status(s);
    chk("R10 status", s, 8'h00);

    // Table walk: R1 R2 R3 R4 R5 R9
    prev = 8'h00;
    for (int i = 0; i < 8; i++) begin
      wp_n = VEC[i][16];
      wren(8);
      read_status(s);
      chk("R1 latch set", s, prev | 8'h02);
      wrsr(VEC[i][15:8], 16);
      read_status(s);
      imm = VEC[i][1] ? VEC[i][7:0] : (VEC[i][7:0] | 8'h03);
      chk("R5/R9 during cycle", s, imm);
      repeat (WCYC + 50) @(negedge clk);
      read_status(s);
      chk("R4/R6/R9 after cycle", s, VEC[i][7:0]);
      prev = VEC[i][7:0];
    end

    wp_n = 1'b1;
    chk("R7 idle output enable", {7'b0, sdo_en}, 8'h00);
    // R6: valid write clears latch at end
    wrsr(8'h00, 16);
    repeat (WCYC + 50) @(negedge clk);
    read_status(s);
    chk("R6 latch cleared", s, 8'h00);
    // R1: write without latch
    wrsr(8'h8C, 16);
    repeat (20) @(negedge clk);
    read_status(s);
    chk("R1 no latch no write", s, 8'h00);
    // R1: write enable with 9 bits ignored
    wren(9);
    read_status(s);
    chk("R1 wren bit count", s, 8'h00);
    // R2: unknown opcode ignored
    begin
      spi_xfer({8'h07, 16'h0}, 8, rx);
      read_status(s);
      chk("R2 unknown code", s, 8'h00);
    end
    // R3: wrong bit counts
    wren(8);
    wrsr(8'h8C, 15);
    read_status(s);
    chk("R3 short write", s, 8'h02);
    wrsr(8'h8C, 17);
    read_status(s);
    chk("R3 long write", s, 8'h02);
    // R8: write during busy ignored
    wrsr(8'h0C, 16);
    wrsr(8'h80, 16);
    repeat (WCYC + 50) @(negedge clk);
    read_status(s);
    chk("R8 busy write ignored", s, 8'h0C);
    // R5 polling
    wren(8);
    wrsr(8'h84, 16);
    saw_busy = 1'b0;
    for (int k = 0; k < 30; k++) begin
      read_status(s);
      if (s[0]) saw_busy = 1'b1;
      else break;
    end
    chk("R5 polled busy", {7'b0, saw_busy}, 8'h01);
    chk("R6 after polling", s, 8'h84);
    // R7: continuous read
    spi_xfer({8'h05, 16'h0}, 24, rx);
    chk("R7 first byte", rx[15:8], 8'h84);
    chk("R7 repeat byte", rx[7:0], 8'h84);
    chk("R7 idle after read", {7'b0, sdo_en}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule